// File: doc/BRIEF.md
# Saturating Wiper Position Counter

This block keeps the tap position of a 101-tap resistor ladder as a 7-bit value from 0 to 100. It decodes that value into a registered one-hot tap select that drives the analog switches. After reset it waits a programmable number of system clocks. It then asks the non-volatile store for word 0 and takes its position field as the starting tap. A stored value outside the ladder's range is replaced with mid-scale.

Once the recall has finished, the block accepts commands from an upstream serial command controller. All of them arrive as single-cycle strobes in the system clock domain:
- a memory transfer carrying a full 16-bit word;
- a direct load assembled bit by bit, least significant bit first;
- step pulses that move the wiper one tap up or down and stop at the ends of the ladder.

A readback shift register presents the current position one bit at a time, in the same bit order used for loading. A settle flag drops whenever the position actually changes. It rises again after a programmable number of clocks, so the analog side has time to stabilise.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: While reset is asserted, the position is 0, the tap select has only line 0 set, `ready` and `recall_req` are low, and `settled` is high.
- R2: `recall_req` rises RECALL_DLY clock edges after reset is released. It stays high until a cycle with `mem_valid` high. On the following edge `recall_req` falls and `ready` rises, and `ready` then stays high until the next reset.
- R3: The recalled position is bits 14:8 of `mem_word`, and bit 15 is ignored. If that 7-bit value is above 100, the position becomes 50.
- R4: Before `ready` is high, the position does not change on transfer, load-commit or step strobes.
- R5: When `step_en` and `step_tick` are both high, the position moves by one tap on the next edge: up when `step_up` is 1, down when it is 0. A `step_tick` pulse while `step_en` is low has no effect.
- R6: A step up at position 100 and a step down at position 0 leave the position unchanged. The position never exceeds 100.
- R7: Each `sin_valid` cycle shifts `sin_bit` into a 7-bit load register, filling it least significant bit first, so the seventh bit received becomes bit 6. `sin_commit` copies the register into the position, limiting the value to 100.
- R8: `xfer_valid` loads bits 14:8 of `mem_word` into the position, limiting the value to 100.
- R9: When several update strobes arrive in the same cycle, the transfer has the highest priority, then the load commit, then the step.
- R10: `rd_load` captures the position into a readback register. Each `rd_shift` shifts that register right. `rd_bit` always shows the register's bit 0, so the position comes out least significant bit first.
- R11: The tap select is one-hot, with the line indexed by the position set, and it changes on the same edge as the position.
- R12: On any edge that changes the position, `settled` goes low. It stays low for SETTLE_CYC cycles and then returns high. A strobe that leaves the value unchanged does not lower it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_word | input | 16 | Word from the non-volatile store, with the position field in bits 14:8 |
| mem_valid | input | 1 | Store answer valid for the power-up recall |
| recall_req | output | 1 | Request for stored word 0 |
| ready | output | 1 | Power-up recall finished, commands accepted |
| step_en | input | 1 | Step command active |
| step_tick | input | 1 | One pulse per step clock |
| step_up | input | 1 | Step direction, 1 moves toward tap 100 |
| sin_valid | input | 1 | Load bit valid |
| sin_bit | input | 1 | Serial load bit, least significant bit first |
| sin_commit | input | 1 | Apply the load register to the position |
| xfer_valid | input | 1 | Apply the field of `mem_word` to the position |
| rd_load | input | 1 | Capture the position for readback |
| rd_shift | input | 1 | Advance the readback register |
| rd_bit | output | 1 | Current readback bit |
| pos | output | 7 | Current tap position |
| tap | output | 101 | One-hot tap select |
| settled | output | 1 | High once the last change has settled |

## Verification
Every result has a fixed latency.
- Position, tap select and the falling edge of `settled` follow the edge that samples the strobe, one cycle later.
- `rd_bit` changes one edge after `rd_load` or `rd_shift`.
- `recall_req` rises RECALL_DLY edges after reset is released, and `ready` rises one edge after `mem_valid`.
- `settled` rises SETTLE_CYC edges after the change.

The bench drives inputs 2 ns after a rising edge and advances a behavioural model by exactly one edge per clock. It compares every output 2 ns after the next edge, so each of these delays is checked cycle by cycle rather than sampled loosely.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  // power-up recall phases
  typedef enum logic [1:0] {
    RS_WAIT = 2'd0,
    RS_REQ  = 2'd1,
    RS_IDLE = 2'd2
  } rcl_state_e;

  // source selected for the next position value
  typedef enum logic [2:0] {
    SRC_HOLD   = 3'd0,
    SRC_RECALL = 3'd1,
    SRC_XFER   = 3'd2,
    SRC_LOAD   = 3'd3,
    SRC_STEP   = 3'd4
  } upd_src_e;

endpackage

// File: rtl/wiper_recall_seq.sv
module wiper_recall_seq
  import wiper_pkg::*;
#(
  parameter int DLY_CYC = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mem_valid,
  output logic recall_req,
  output logic recall_fire,
  output logic ready
);

  localparam int CNT_W = $clog2(DLY_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DLY_CYC - 1);

  rcl_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      RS_WAIT: begin
        cnt_en = 1'b1;
        if (cnt_q == LAST_CNT) begin
          state_d = RS_REQ;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      RS_REQ: begin
        if (mem_valid) state_d = RS_IDLE;
      end
      default: state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_WAIT;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign recall_req  = (state_q == RS_REQ);
  assign recall_fire = (state_q == RS_REQ) && mem_valid;
  assign ready       = (state_q == RS_IDLE);

endmodule

// File: rtl/wiper_pos_core.sv
module wiper_pos_core
  import wiper_pkg::*;
#(
  parameter int POS_W     = 7,
  parameter int TAP_MAX   = 100,
  parameter int TAP_MID   = 50,
  parameter int WORD_W    = 16,
  parameter int FIELD_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready,
  input  logic              recall_fire,
  input  logic [WORD_W-1:0] mem_word,
  input  logic              step_en,
  input  logic              step_tick,
  input  logic              step_up,
  input  logic              sin_valid,
  input  logic              sin_bit,
  input  logic              sin_commit,
  input  logic              xfer_valid,
  input  logic              rd_load,
  input  logic              rd_shift,
  output logic [POS_W-1:0]  pos_q,
  output logic [POS_W-1:0]  pos_d,
  output logic              pos_chg,
  output logic              rd_bit
);

  localparam logic [POS_W-1:0] MAX_P  = POS_W'(TAP_MAX);
  localparam logic [POS_W-1:0] MID_P  = POS_W'(TAP_MID);
  localparam logic [POS_W-1:0] ZERO_P = '0;

  logic [POS_W-1:0] field;
  logic [POS_W-1:0] rcl_val;
  logic [POS_W-1:0] xfer_val;
  logic [POS_W-1:0] load_val;
  logic [POS_W-1:0] step_val;
  logic [POS_W-1:0] sin_q, sin_d;
  logic [POS_W-1:0] rd_q, rd_d;
  logic             rd_en;
  upd_src_e         src;

  // candidate values
  always_comb begin
    field    = POS_W'(mem_word >> FIELD_LSB);
    rcl_val  = (field > MAX_P) ? MID_P : field;
    xfer_val = (field > MAX_P) ? MAX_P : field;
    load_val = (sin_q > MAX_P) ? MAX_P : sin_q;
    if (step_up) begin
      step_val = (pos_q == MAX_P) ? pos_q : pos_q + 1'b1;
    end else begin
      step_val = (pos_q == ZERO_P) ? pos_q : pos_q - 1'b1;
    end
  end

  // source priority: recall, then transfer, load, step
  always_comb begin
    src = SRC_HOLD;
    if (recall_fire) begin
      src = SRC_RECALL;
    end else if (ready) begin
      if (xfer_valid)                 src = SRC_XFER;
      else if (sin_commit)            src = SRC_LOAD;
      else if (step_en && step_tick)  src = SRC_STEP;
    end
  end

  always_comb begin
    case (src)
      SRC_RECALL: pos_d = rcl_val;
      SRC_XFER:   pos_d = xfer_val;
      SRC_LOAD:   pos_d = load_val;
      SRC_STEP:   pos_d = step_val;
      default:    pos_d = pos_q;
    endcase
    pos_chg = (pos_d != pos_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_chg) begin
      pos_q <= pos_d;
    end
  end

  // serial load register, first bit ends up as bit 0
  always_comb begin
    sin_d = {sin_bit, sin_q[POS_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sin_q <= '0;
    end else if (sin_valid) begin
      sin_q <= sin_d;
    end
  end

  // readback register, bit 0 presented first
  always_comb begin
    rd_en = rd_load || rd_shift;
    if (rd_load) rd_d = pos_q;
    else         rd_d = {1'b0, rd_q[POS_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign rd_bit = rd_q[0];

endmodule

// File: rtl/wiper_tap_dec.sv
module wiper_tap_dec #(
  parameter int POS_W    = 7,
  parameter int NUM_TAPS = 101
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [POS_W-1:0]    pos_d,
  input  logic                pos_chg,
  output logic [NUM_TAPS-1:0] tap_q
);

  localparam logic [NUM_TAPS-1:0] TAP_RST = NUM_TAPS'(1);

  logic [NUM_TAPS-1:0] tap_d;

  for (genvar g = 0; g < NUM_TAPS; g++) begin : g_line
    assign tap_d[g] = (pos_d == POS_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q <= TAP_RST;
    end else if (pos_chg) begin
      tap_q <= tap_d;
    end
  end

endmodule

// File: rtl/wiper_settle.sv
module wiper_settle #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic settled
);

  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = restart || (cnt_q != '0);
    cnt_d  = restart ? LOAD_V : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign settled = (cnt_q == '0);

endmodule

// File: rtl/wiper_pos_ctrl.sv
module wiper_pos_ctrl #(
  parameter int POS_W      = 7,
  parameter int TAP_MAX    = 100,
  parameter int TAP_MID    = 50,
  parameter int WORD_W     = 16,
  parameter int FIELD_LSB  = 8,
  parameter int RECALL_DLY = 40,
  parameter int SETTLE_CYC = 16,
  localparam int NUM_TAPS  = TAP_MAX + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   mem_word,
  input  logic                mem_valid,
  output logic                recall_req,
  output logic                ready,
  input  logic                step_en,
  input  logic                step_tick,
  input  logic                step_up,
  input  logic                sin_valid,
  input  logic                sin_bit,
  input  logic                sin_commit,
  input  logic                xfer_valid,
  input  logic                rd_load,
  input  logic                rd_shift,
  output logic                rd_bit,
  output logic [POS_W-1:0]    pos,
  output logic [NUM_TAPS-1:0] tap,
  output logic                settled
);

  logic             recall_fire;
  logic [POS_W-1:0] pos_d;
  logic             pos_chg;

  wiper_recall_seq #(
    .DLY_CYC (RECALL_DLY)
  ) u_recall (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_valid   (mem_valid),
    .recall_req  (recall_req),
    .recall_fire (recall_fire),
    .ready       (ready)
  );

  wiper_pos_core #(
    .POS_W     (POS_W),
    .TAP_MAX   (TAP_MAX),
    .TAP_MID   (TAP_MID),
    .WORD_W    (WORD_W),
    .FIELD_LSB (FIELD_LSB)
  ) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .ready       (ready),
    .recall_fire (recall_fire),
    .mem_word    (mem_word),
    .step_en     (step_en),
    .step_tick   (step_tick),
    .step_up     (step_up),
    .sin_valid   (sin_valid),
    .sin_bit     (sin_bit),
    .sin_commit  (sin_commit),
    .xfer_valid  (xfer_valid),
    .rd_load     (rd_load),
    .rd_shift    (rd_shift),
    .pos_q       (pos),
    .pos_d       (pos_d),
    .pos_chg     (pos_chg),
    .rd_bit      (rd_bit)
  );

  wiper_tap_dec #(
    .POS_W    (POS_W),
    .NUM_TAPS (NUM_TAPS)
  ) u_tap (
    .clk     (clk),
    .rst_n   (rst_n),
    .pos_d   (pos_d),
    .pos_chg (pos_chg),
    .tap_q   (tap)
  );

  wiper_settle #(
    .SETTLE_CYC (SETTLE_CYC)
  ) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (pos_chg),
    .settled (settled)
  );

endmodule

// File: rtl/wiper_pos_chk.sv
module wiper_pos_chk #(
  parameter int POS_W    = 7,
  parameter int NUM_TAPS = 101,
  parameter int TAP_MAX  = 100
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ready,
  input logic                recall_req,
  input logic                mem_valid,
  input logic                step_en,
  input logic                step_tick,
  input logic                xfer_valid,
  input logic                sin_commit,
  input logic                settled,
  input logic [POS_W-1:0]    pos,
  input logic [NUM_TAPS-1:0] tap
);

  AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(tap) && tap[pos]); // R11

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= POS_W'(TAP_MAX)); // R6

  AST_HOLD_BEFORE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !ready && !(recall_req && mem_valid) |=> $stable(pos)); // R4

  AST_STEP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    ready && step_en && step_tick && !xfer_valid && !sin_commit |=>
      ({1'b0, pos} == {1'b0, $past(pos)} + 8'd1) ||
      ({1'b0, pos} + 8'd1 == {1'b0, $past(pos)}) ||
      (pos == $past(pos))); // R5

  AST_SETTLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos) |-> !settled); // R12

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req && !mem_valid |=> recall_req); // R2

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R2

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !recall_req); // R2

endmodule

bind wiper_pos_ctrl wiper_pos_chk #(
  .POS_W    (POS_W),
  .NUM_TAPS (NUM_TAPS),
  .TAP_MAX  (TAP_MAX)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (ready),
  .recall_req (recall_req),
  .mem_valid  (mem_valid),
  .step_en    (step_en),
  .step_tick  (step_tick),
  .xfer_valid (xfer_valid),
  .sin_commit (sin_commit),
  .settled    (settled),
  .pos        (pos),
  .tap        (tap)
);

// File: tb/wiper_pos_ctrl_tb_top.sv
module wiper_pos_ctrl_tb_top;

  localparam int DLY = 12;
  localparam int SET = 5;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [15:0]  mem_word;
  logic         mem_valid, step_en, step_tick, step_up;
  logic         sin_valid, sin_bit, sin_commit, xfer_valid, rd_load, rd_shift;
  logic         recall_req, ready, rd_bit, settled;
  logic [6:0]   pos;
  logic [100:0] tap;

  int n_chk = 0;
  int n_err = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_pos, m_sin, m_rd, m_scnt, m_elapsed;
  bit m_req, m_ready;

  always #4 clk = ~clk;

  wiper_pos_ctrl #(
    .RECALL_DLY (DLY),
    .SETTLE_CYC (SET)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .mem_word (mem_word), .mem_valid (mem_valid),
    .recall_req (recall_req), .ready (ready), .step_en (step_en),
    .step_tick (step_tick), .step_up (step_up), .sin_valid (sin_valid),
    .sin_bit (sin_bit), .sin_commit (sin_commit), .xfer_valid (xfer_valid),
    .rd_load (rd_load), .rd_shift (rd_shift), .rd_bit (rd_bit), .pos (pos),
    .tap (tap), .settled (settled)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_tap(int exp_pos);
    logic [100:0] exp_tap;
    exp_tap = 101'd1 << exp_pos;
    n_chk++;
    if (tap !== exp_tap) begin
      n_err++;
      $display("FAIL R11 tap: actual=%h expected=%h at %0t", tap, exp_tap, $time);
    end
  endtask

  task automatic compare_all();
    chk(cur_req, "pos", int'(pos), m_pos);
    chk_tap(m_pos);
    chk("R12", "settled", int'(settled), (m_scnt == 0) ? 1 : 0);
    chk("R2", "ready", int'(ready), int'(m_ready));
    chk("R2", "recall_req", int'(recall_req), int'(m_req));
    chk("R10", "rd_bit", int'(rd_bit), m_rd & 1);
  endtask

  // advance the model by one clock edge using the inputs held before it
  task automatic model_edge();
    int npos, v;
    npos = m_pos;
    v = (int'(mem_word) >> 8) & 127;
    if (!m_ready) begin
      if (m_req && mem_valid) begin
        npos = (v > 100) ? 50 : v;
        m_req = 1'b0;
        m_ready = 1'b1;
      end else if (!m_req) begin
        m_elapsed++;
        if (m_elapsed == DLY) m_req = 1'b1;
      end
    end else begin
      if (xfer_valid)                npos = (v > 100) ? 100 : v;
      else if (sin_commit)           npos = (m_sin > 100) ? 100 : m_sin;
      else if (step_en && step_tick) begin
        if (step_up) npos = (m_pos < 100) ? m_pos + 1 : m_pos;
        else         npos = (m_pos > 0)   ? m_pos - 1 : m_pos;
      end
    end
    if (rd_load)       m_rd = m_pos;
    else if (rd_shift) m_rd = m_rd >> 1;
    if (sin_valid) m_sin = (m_sin >> 1) | (int'(sin_bit) << 6);
    if (npos != m_pos)   m_scnt = SET;
    else if (m_scnt > 0) m_scnt--;
    m_pos = npos;
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      model_edge();
      @(posedge clk);
      #2;
      compare_all();
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    mem_word = '0; mem_valid = 0; step_en = 0; step_tick = 0; step_up = 0;
    sin_valid = 0; sin_bit = 0; sin_commit = 0; xfer_valid = 0;
    rd_load = 0; rd_shift = 0;
    m_pos = 0; m_sin = 0; m_rd = 0; m_scnt = 0; m_elapsed = 0;
    m_req = 0; m_ready = 0;
    repeat (2) @(posedge clk);
    #2;
    chk("R1", "reset pos", int'(pos), 0);
    chk("R1", "reset tap", (tap == 101'd1) ? 1 : 0, 1);
    chk("R1", "reset ready", int'(ready), 0);
    chk("R1", "reset recall_req", int'(recall_req), 0);
    chk("R1", "reset settled", int'(settled), 1);
    rst_n = 1'b1;
  endtask

  task automatic do_recall(logic [15:0] w);
    while (!m_req) cyc(1);
    cyc(2);
    mem_word = w; mem_valid = 1'b1;
    cyc(1);
    mem_valid = 1'b0;
  endtask

  task automatic do_xfer(logic [15:0] w);
    mem_word = w; xfer_valid = 1'b1;
    cyc(1);
    xfer_valid = 1'b0;
  endtask

  task automatic shift_in(int val);
    for (int i = 0; i < 7; i++) begin
      sin_valid = 1'b1;
      sin_bit = 1'((val >> i) & 1);
      cyc(1);
    end
    sin_valid = 1'b0;
  endtask

  task automatic commit();
    sin_commit = 1'b1;
    cyc(1);
    sin_commit = 1'b0;
  endtask

  task automatic steps(bit up, int n);
    step_en = 1'b1; step_up = up;
    for (int i = 0; i < n; i++) begin
      step_tick = 1'b1; cyc(1);
      step_tick = 1'b0; cyc(1);
    end
    step_en = 1'b0;
  endtask

  task automatic readback();
    rd_load = 1'b1; cyc(1); rd_load = 1'b0;
    for (int i = 0; i < 7; i++) begin
      rd_shift = 1'b1; cyc(1);
    end
    rd_shift = 1'b0;
    cyc(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R2 watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R4: strobes during the recall wait are ignored
    cur_req = "R4";
    mem_word = 16'h3000; xfer_valid = 1; sin_commit = 1; step_en = 1; step_tick = 1; step_up = 1;
    cyc(3);
    xfer_valid = 0; sin_commit = 0; step_en = 0; step_tick = 0;
    // R3: out-of-range recall with bit 15 set goes to mid-scale
    cur_req = "R3";
    do_recall(16'hE53C);
    cyc(SET + 2);
    // R5: stepping both ways, then ticks without enable
    cur_req = "R5";
    steps(1, 3);
    steps(0, 2);
    step_tick = 1; cyc(2); step_tick = 0; cyc(1);
    // R8: transfers with and without clamp
    cur_req = "R8";
    do_xfer(16'h7F00);
    do_xfer(16'h6200);
    // R6: saturation at both ends
    cur_req = "R6";
    steps(1, 4);
    do_xfer(16'h0200);
    steps(0, 4);
    // R7: serial loads, in range and clamped
    cur_req = "R7";
    shift_in(90); commit();
    shift_in(112); commit();
    // R9: priority among simultaneous strobes
    cur_req = "R9";
    shift_in(20);
    mem_word = 16'h0A00; xfer_valid = 1; sin_commit = 1; step_en = 1; step_tick = 1; step_up = 1;
    cyc(1);
    xfer_valid = 0;
    cyc(1);
    sin_commit = 0;
    cyc(1);
    step_en = 0; step_tick = 0;
    // R10: readback order
    cur_req = "R10";
    readback();
    // R12: settle recovery
    cur_req = "R12";
    cyc(SET + 3);
    // second power-up: in-range recall, bit 15 ignored
    do_reset();
    cur_req = "R3";
    do_recall(16'hA300);
    readback();
    cyc(SET + 2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule